// File: doc/BRIEF.md
# Thread/Handler Mode and Stack Selector

This block tracks the two-level execution model of a small microcontroller core. The core runs application code in thread mode and services exceptions in handler mode. A two-bit control register sets two things for thread mode: whether code runs privileged, and whether it uses the main stack or the process stack. The block drives the current mode, the effective privilege level and the stack-select line that picks the active stack pointer.

Exception entry moves the core into handler mode and increments a nesting counter. Each exception return decrements that counter. The core goes back to thread mode only when the counter reaches zero, and on that return a flag chooses the stack thread mode resumes on. Handler mode always runs privileged on the main stack, whatever the control bits hold. A control write takes effect only when the core is privileged at the time of the write.

The mode machine has two states. `MODE_THREAD` is the reset state. `MODE_HANDLER` covers every exception level. Its transitions are:
- ENTER: from thread to handler on entry.
- NEST: handler to handler on entry, which increments the count.
- UNNEST: handler to handler on a return while the count is above one.
- RESUME: from handler to thread on a return while the count is one.

Top module: `exec_mode_ctrl`

## Requirements
- R1: After reset the block is in thread mode, privileged, on the main stack (`in_handler`=0, `privileged`=1, `sp_proc`=0), and both control bits are zero.
- R2: In thread mode, `privileged` is the inverse of control bit 0, where bit 0 = 1 means unprivileged.
- R3: In thread mode, `sp_proc` equals control bit 1, where bit 1 = 1 selects the process stack.
- R4: A `ctrl_wr` pulse loads `ctrl_wdata` into the control bits when the core is privileged in that cycle, and the new bits show at the outputs after the next clock edge. A write made while the core is unprivileged leaves the bits and the outputs unchanged.
- R5: In handler mode, `privileged`=1 and `sp_proc`=0, whatever the control bits hold.
- R6: `exc_entry` puts the block in handler mode after the next edge. Nested entries increment a counter up to MAX_NEST. An entry at MAX_NEST is ignored.
- R7: `exc_return` in handler mode decrements the counter, and the block goes back to thread mode only on the return that takes the counter from one to zero. `exc_return` in thread mode is ignored.
- R8: A control write made in handler mode is stored. Its privilege bit takes effect once the block is back in thread mode.
- R9: On the return to thread mode, control bit 1 is loaded from `exc_ret_psp` (1 = process stack). This overrides bit 1 of any write in the same cycle.
- R10: When `exc_entry` and `exc_return` are both high in the same cycle, the entry is taken and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_entry | input | 1 | Exception entry pulse |
| exc_return | input | 1 | Exception return pulse |
| exc_ret_psp | input | 1 | Stack flag for the return to thread mode (1 = process) |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 2 | Control data: bit 0 = unprivileged, bit 1 = process stack |
| in_handler | output | 1 | 1 in handler mode, 0 in thread mode |
| privileged | output | 1 | Effective privilege level |
| sp_proc | output | 1 | 1 selects the process stack pointer, 0 the main one |

## Verification
The bench targets these cases:
- Nested exceptions. A design that leaves handler mode on the first return, rather than when the count runs out, shows thread mode early.
- Saturation. Entries past MAX_NEST must not grow the count, or the matching returns leave the block stuck in handler mode.
- Writes made while unprivileged. Ungated writes would let thread code regain privilege on its own.
- Writes made in handler mode. A design that exposes the stored bits in handler mode drops privilege or switches stack inside a handler.
- Coinciding events. These are entry together with a return, a return in thread mode, and a write on the final return. Getting their priority wrong shows up as a wrong mode, or as a stack bit that ignores the return flag.

// File: rtl/exec_mode_pkg.sv
package exec_mode_pkg;
    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } core_mode_e;

    typedef struct packed {
        logic use_proc;   // bit 1: process stack in thread mode
        logic drop_priv;  // bit 0: unprivileged in thread mode
    } ctrl_bits_t;
endpackage

// File: rtl/exec_mode_fsm.sv
module exec_mode_fsm
    import exec_mode_pkg::*;
#(
    parameter int MAX_NEST = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exc_entry,
    input  logic       exc_return,
    output core_mode_e mode_o,
    output logic       resume_o
);
    localparam int DW = $clog2(MAX_NEST + 1);
    localparam logic [DW-1:0] DEPTH_MAX = DW'(MAX_NEST);
    localparam logic [DW-1:0] DEPTH_ONE = DW'(1);

    core_mode_e    state_q, state_d;
    logic [DW-1:0] depth_q, depth_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_THREAD;
            depth_q <= '0;
        end else begin
            state_q <= state_d;
            depth_q <= depth_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        depth_d  = depth_q;
        resume_o = 1'b0;
        unique case (state_q)
            MODE_THREAD: begin
                if (exc_entry) begin            // ENTER
                    state_d = MODE_HANDLER;
                    depth_d = DEPTH_ONE;
                end
            end
            MODE_HANDLER: begin
                if (exc_entry) begin            // NEST
                    if (depth_q != DEPTH_MAX) depth_d = depth_q + DEPTH_ONE;
                end else if (exc_return) begin
                    depth_d = depth_q - DEPTH_ONE;
                    if (depth_q == DEPTH_ONE) begin   // RESUME
                        state_d  = MODE_THREAD;
                        resume_o = 1'b1;
                    end                               // else UNNEST
                end
            end
        endcase
    end

    assign mode_o = state_q;
endmodule

// File: rtl/exec_mode_ctrl_reg.sv
module exec_mode_ctrl_reg
    import exec_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wdata,
    input  logic       allow,
    input  logic       resume,
    input  logic       resume_psp,
    output ctrl_bits_t bits_o
);
    ctrl_bits_t bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            if (wr_en && allow) bits_q <= ctrl_bits_t'(wdata);
            if (resume)         bits_q.use_proc <= resume_psp;
        end
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/exec_mode_view.sv
module exec_mode_view
    import exec_mode_pkg::*;
(
    input  core_mode_e mode,
    input  ctrl_bits_t bits,
    output logic       in_handler,
    output logic       privileged,
    output logic       sp_proc
);
    always_comb begin
        unique case (mode)
            MODE_THREAD: begin
                in_handler = 1'b0;
                privileged = ~bits.drop_priv;
                sp_proc    = bits.use_proc;
            end
            MODE_HANDLER: begin
                in_handler = 1'b1;
                privileged = 1'b1;
                sp_proc    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/exec_mode_ctrl.sv
module exec_mode_ctrl
    import exec_mode_pkg::*;
#(
    parameter int MAX_NEST = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exc_entry,
    input  logic       exc_return,
    input  logic       exc_ret_psp,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_wdata,
    output logic       in_handler,
    output logic       privileged,
    output logic       sp_proc
);
    core_mode_e mode;
    ctrl_bits_t bits;
    logic       resume;

    exec_mode_fsm #(.MAX_NEST(MAX_NEST)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_entry (exc_entry),
        .exc_return(exc_return),
        .mode_o    (mode),
        .resume_o  (resume)
    );

    exec_mode_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_wr),
        .wdata     (ctrl_wdata),
        .allow     (privileged),
        .resume    (resume),
        .resume_psp(exc_ret_psp),
        .bits_o    (bits)
    );

    exec_mode_view u_view (
        .mode      (mode),
        .bits      (bits),
        .in_handler(in_handler),
        .privileged(privileged),
        .sp_proc   (sp_proc)
    );
endmodule

// File: rtl/exec_mode_ctrl_chk.sv
module exec_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic exc_entry,
    input logic exc_return,
    input logic ctrl_wr,
    input logic in_handler,
    input logic privileged,
    input logic sp_proc
);
    assert_handler_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_handler |-> (privileged && !sp_proc));

    assert_entry_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && exc_entry) |=> in_handler);

    assert_thread_return_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && exc_return && !exc_entry) |=> !in_handler);

    assert_unpriv_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler && !privileged && ctrl_wr && !exc_entry)
            |=> ($stable(privileged) && $stable(sp_proc) && !in_handler));

    assert_entry_beats_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && exc_return) |=> in_handler);

    assert_no_self_promotion_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(privileged) && !in_handler) |-> $past(in_handler));
endmodule

bind exec_mode_ctrl exec_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_entry (exc_entry),
    .exc_return(exc_return),
    .ctrl_wr   (ctrl_wr),
    .in_handler(in_handler),
    .privileged(privileged),
    .sp_proc   (sp_proc)
);

// File: tb/exec_mode_ctrl_tb.sv
module exec_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_NEST   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exc_entry = 1'b0, exc_return = 1'b0, exc_ret_psp = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [1:0] ctrl_wdata = 2'b00;
    logic       in_handler, privileged, sp_proc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference state
    int m_handler = 0, m_depth = 0, m_b0 = 0, m_b1 = 0;

    exec_mode_ctrl #(.MAX_NEST(MAX_NEST)) u_dut (
        .clk(clk), .rst_n(rst_n), .exc_entry(exc_entry), .exc_return(exc_return),
        .exc_ret_psp(exc_ret_psp), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .in_handler(in_handler), .privileged(privileged), .sp_proc(sp_proc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_handler = 0; m_depth = 0; m_b0 = 0; m_b1 = 0;
        end else begin
            automatic int pv = (m_handler != 0 || m_b0 == 0) ? 1 : 0;
            if (ctrl_wr && pv != 0) begin m_b0 = ctrl_wdata[0]; m_b1 = ctrl_wdata[1]; end
            if (exc_entry) begin
                if (m_handler == 0) begin m_handler = 1; m_depth = 1; end
                else if (m_depth < MAX_NEST) m_depth++;
            end else if (exc_return && m_handler != 0) begin
                m_depth--;
                if (m_depth == 0) begin m_handler = 0; m_b1 = exc_ret_psp; end
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6", "in_handler", in_handler, m_handler);
            check(m_handler != 0 ? "R5" : "R2", "privileged", privileged,
                  (m_handler != 0 || m_b0 == 0) ? 1 : 0);
            check(m_handler != 0 ? "R5" : "R3", "sp_proc", sp_proc,
                  m_handler != 0 ? 0 : m_b1);
        end
    end

    task automatic step(input logic en, input logic rt, input logic fl,
                        input logic wr, input logic [1:0] wd);
        @(negedge clk);
        exc_entry = en; exc_return = rt; exc_ret_psp = fl; ctrl_wr = wr; ctrl_wdata = wd;
        @(negedge clk);
        exc_entry = 1'b0; exc_return = 1'b0; exc_ret_psp = 1'b0; ctrl_wr = 1'b0;
    endtask

    task automatic expect3(input string req, input int h, input int p, input int s);
        check(req, "in_handler", in_handler, h);
        check(req, "privileged", privileged, p);
        check(req, "sp_proc", sp_proc, s);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect3("R1", 0, 1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect3("R1", 0, 1, 0);

        step(0, 0, 0, 1, 2'b10);     expect3("R4", 0, 1, 1);   // R3 process stack
        step(1, 0, 0, 0, 2'b00);     expect3("R5", 1, 1, 0);   // R6 enter
        step(1, 0, 0, 0, 2'b00);
        step(1, 0, 0, 0, 2'b00);
        step(0, 1, 0, 0, 2'b00);     expect3("R7", 1, 1, 0);
        step(0, 1, 0, 0, 2'b00);     expect3("R7", 1, 1, 0);
        step(0, 1, 1, 0, 2'b00);     expect3("R9", 0, 1, 1);

        step(1, 0, 0, 0, 2'b00);
        step(0, 0, 0, 1, 2'b01);     expect3("R8", 1, 1, 0);
        step(0, 1, 0, 0, 2'b00);     expect3("R8", 0, 0, 0);

        step(0, 0, 0, 1, 2'b00);     expect3("R4", 0, 0, 0);   // unprivileged write
        step(0, 1, 1, 0, 2'b00);     expect3("R7", 0, 0, 0);   // return in thread
        step(1, 1, 1, 0, 2'b00);     expect3("R10", 1, 1, 0);
        step(0, 1, 0, 1, 2'b10);     expect3("R9", 0, 1, 0);   // flag beats write bit 1

        for (int i = 0; i < MAX_NEST + 2; i++) step(1, 0, 0, 0, 2'b00);
        for (int i = 0; i < MAX_NEST - 1; i++) step(0, 1, 0, 0, 2'b00);
        expect3("R6", 1, 1, 0);
        step(0, 1, 1, 0, 2'b00);     expect3("R6", 0, 1, 1);   // saturated count

        for (int i = 0; i < 400; i++) begin
            automatic int r = $urandom_range(0, 15);
            step(r < 4, (r >= 3 && r < 9), $urandom_range(0, 1) != 0,
                 $urandom_range(0, 2) == 0, 2'($urandom_range(0, 3)));
        end

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule